// File: doc/BRIEF.md
# Scanline Interrupt Counter With Offset

This block raises an interrupt at a chosen video line. The CPU loads an 8-bit counter one nibble at a time, writes a nonzero enable byte, and can arm a fixed offset of 16. From then on, every one-cycle line pulse from the video side adds one to the counter, wrapping from 255 to 0. When the value after the step, less the offset, equals 238, the block raises a level interrupt request. The request stays high until the CPU writes the enable register again.

Register selection compares the write address, masked with 0xF80C, against four values. 0xF000 loads the counter's low nibble and 0xF004 loads its high nibble. 0xF008 takes the enable byte and also acknowledges the interrupt. 0xF00C arms the offset. Any other masked value leaves the state unchanged. The difference is taken wide enough to keep its sign, so a counter below the offset never matches.

Top module: `scanline_irq_counter`

## Requirements
- R1: A write whose masked address (addr & 0xF80C) is 0xF000 replaces counter bits 3:0 with data bits 3:0. Bits 7:4 of the counter are kept and data bits 7:4 are ignored.
- R2: A write whose masked address is 0xF004 replaces counter bits 7:4 with data bits 3:0 and keeps bits 3:0.
- R3: A write whose masked address is 0xF008 stores the whole data byte as the enable value. When that byte is zero, the same write also clears the offset to 0.
- R4: A write whose masked address is 0xF008 drops irq_o on the next clock edge, unless a match occurs in the same cycle.
- R5: A write whose masked address is 0xF00C sets the offset to 16, whatever the data.
- R6: On a cycle where line_tick is high and the stored enable is nonzero, the counter increments modulo 256. While the enable is zero, line_tick has no effect.
- R7: When an increment makes (counter − offset), taken as a signed value, equal to 238, irq_o goes high at that same clock edge. It then stays high until an acknowledge or a reset.
- R8: Reset clears the counter, the offset, the enable and irq_o.
- R9: A write whose masked address matches none of the four values changes no state.
- R10: A counter nibble write in the same cycle as a line tick takes effect, and the tick is dropped for that cycle.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle pulse per video line |
| irq_o | output | 1 | Level interrupt request, active high |

## Verification
The counter value can only be seen through the timing of irq_o. The bench therefore measures it. It loads each of the 256 start values, with and without the offset, then counts line ticks until the request rises. It checks the exact tick on which irq_o must rise, and that it is still low one tick before. The hardest case is the full-wrap case, where the start value already equals the compare point and the request needs 256 ticks. The sweep covers it with both offsets, and it also covers the counter values below the offset that must never match.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_LO   = 3'd1,
    SEL_HI   = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_OFS  = 3'd4
  } sel_e;

  localparam int unsigned DEF_ADDR_W = 16;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_NIB_W  = 4;
  localparam int unsigned DEF_TARGET = 238;
  localparam int unsigned DEF_OFS    = 16;
endpackage

// File: rtl/sirq_rst_sync.sv
module sirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sirq_decode.sv
module sirq_decode
  import sirq_pkg::*;
#(
  parameter int unsigned     ADDR_W = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] MASK   = 16'hF80C,
  parameter logic [ADDR_W-1:0] A_LO   = 16'hF000,
  parameter logic [ADDR_W-1:0] A_HI   = 16'hF004,
  parameter logic [ADDR_W-1:0] A_CTRL = 16'hF008,
  parameter logic [ADDR_W-1:0] A_OFS  = 16'hF00C
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output sel_e              sel
);
  logic [ADDR_W-1:0] masked;

  always_comb begin
    masked = wr_addr & MASK;
    sel    = SEL_NONE;
    if (wr_en) begin
      if (masked == A_LO) begin
        sel = SEL_LO;
      end else if (masked == A_HI) begin
        sel = SEL_HI;
      end else if (masked == A_CTRL) begin
        sel = SEL_CTRL;
      end else if (masked == A_OFS) begin
        sel = SEL_OFS;
      end
    end
  end
endmodule

// File: rtl/sirq_count.sv
module sirq_count
  import sirq_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned NIB_W  = DEF_NIB_W,
  parameter int unsigned OFS    = DEF_OFS,
  localparam int unsigned CNT_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_tick,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cnt_d,
  output logic [CNT_W-1:0]  ofs_q,
  output logic [DATA_W-1:0] en_q,
  output logic              step
);
  logic [CNT_W-1:0]  ofs_d;
  logic [DATA_W-1:0] en_d;
  logic              nib_wr;
  logic              cnt_ce;
  logic              cfg_ce;

  always_comb begin
    cnt_d  = cnt_q;
    ofs_d  = ofs_q;
    en_d   = en_q;
    nib_wr = (sel == SEL_LO) || (sel == SEL_HI);
    step   = line_tick && (en_q != '0) && !nib_wr;
    unique case (sel)
      SEL_LO:   cnt_d[NIB_W-1:0]     = wr_data[NIB_W-1:0];
      SEL_HI:   cnt_d[CNT_W-1:NIB_W] = wr_data[NIB_W-1:0];
      SEL_CTRL: begin
        en_d = wr_data;
        if (wr_data == '0) begin
          ofs_d = '0;
        end
      end
      SEL_OFS:  ofs_d = CNT_W'(OFS);
      default:  ;
    endcase
    if (step) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    cnt_ce = nib_wr || step;
    cfg_ce = (sel == SEL_CTRL) || (sel == SEL_OFS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
      en_q  <= '0;
    end else if (cfg_ce) begin
      ofs_q <= ofs_d;
      en_q  <= en_d;
    end
  end
endmodule

// File: rtl/sirq_flag.sv
module sirq_flag
  import sirq_pkg::*;
#(
  parameter int unsigned CNT_W  = 2 * DEF_NIB_W,
  parameter int unsigned TARGET = DEF_TARGET,
  localparam int unsigned DIFF_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] ofs_q,
  input  sel_e             sel,
  output logic             irq_q
);
  logic [DIFF_W-1:0] diff;
  logic              hit;
  logic              ack;
  logic              irq_d;

  always_comb begin
    diff  = {2'b00, cnt_d} - {2'b00, ofs_q};
    hit   = step && (diff == DIFF_W'(TARGET));
    ack   = (sel == SEL_CTRL);
    irq_d = irq_q;
    if (ack) begin
      irq_d = 1'b0;
    end
    if (hit) begin
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (ack || hit) begin
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import sirq_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned NIB_W  = DEF_NIB_W,
  parameter int unsigned TARGET = DEF_TARGET,
  parameter int unsigned OFS    = DEF_OFS,
  localparam int unsigned CNT_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_tick,
  output logic              irq_o
);
  logic              rst_sync_n;
  sel_e              sel;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic [CNT_W-1:0]  ofs_q;
  logic [DATA_W-1:0] en_q;
  logic              step;

  sirq_rst_sync #(.STAGES(2)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sirq_decode #(.ADDR_W(ADDR_W)) i_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .sel     (sel)
  );

  sirq_count #(.DATA_W(DATA_W), .NIB_W(NIB_W), .OFS(OFS)) i_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel       (sel),
    .wr_data   (wr_data),
    .line_tick (line_tick),
    .cnt_q     (cnt_q),
    .cnt_d     (cnt_d),
    .ofs_q     (ofs_q),
    .en_q      (en_q),
    .step      (step)
  );

  sirq_flag #(.CNT_W(CNT_W), .TARGET(TARGET)) i_flag (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .step  (step),
    .cnt_d (cnt_d),
    .ofs_q (ofs_q),
    .sel   (sel),
    .irq_q (irq_o)
  );
endmodule

// File: rtl/sirq_chk.sv
module sirq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              line_tick,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  ofs_q,
  input logic [DATA_W-1:0] en_q
);
  localparam int unsigned HALF = CNT_W / 2;
  logic [ADDR_W-1:0] m;
  logic w_lo, w_hi, w_ctrl, w_ofs, w_any;

  always_comb begin
    m      = wr_addr & ADDR_W'(16'hF80C);
    w_lo   = wr_en && (m == ADDR_W'(16'hF000));
    w_hi   = wr_en && (m == ADDR_W'(16'hF004));
    w_ctrl = wr_en && (m == ADDR_W'(16'hF008));
    w_ofs  = wr_en && (m == ADDR_W'(16'hF00C));
    w_any  = w_lo || w_hi || w_ctrl || w_ofs;
  end

  AST_LO_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    w_lo |=> (cnt_q[HALF-1:0] == $past(wr_data[HALF-1:0])) && (cnt_q[CNT_W-1:HALF] == $past(cnt_q[CNT_W-1:HALF]))); // R1
  AST_HI_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    w_hi |=> (cnt_q[CNT_W-1:HALF] == $past(wr_data[HALF-1:0])) && (cnt_q[HALF-1:0] == $past(cnt_q[HALF-1:0]))); // R2
  AST_EN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    w_ctrl |=> en_q == $past(wr_data)); // R3
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && !line_tick) |=> !irq_o); // R4
  AST_OFS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    w_ofs |=> ofs_q == CNT_W'(16)); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && (en_q != '0) && !w_lo && !w_hi) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R6
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_tick && !w_lo && !w_hi) |=> $stable(cnt_q)); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !w_ctrl) |=> irq_o); // R7
  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !line_tick) |=> !irq_o); // R7
  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !w_any |=> $stable(ofs_q) && $stable(en_q)); // R9
endmodule

bind scanline_irq_counter sirq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .line_tick (line_tick),
  .irq_o     (irq_o),
  .cnt_q     (cnt_q),
  .ofs_q     (ofs_q),
  .en_q      (en_q)
);

// File: tb/test_scanline_irq_counter.sv
module test_scanline_irq_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        line_tick;
  logic        irq_o;
  int          n_chk;
  int          n_fail;

  scanline_irq_counter i_scanline_irq_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_tick(line_tick), .irq_o(irq_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s irq_o actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_tick = 1'b1;
    end
    @(negedge clk);
    line_tick = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    wr(16'hF000, {4'hA, v[3:0]});
    wr(16'hF004, {4'h5, v[7:4]});
  endtask

  task automatic setup(input logic ofs_on);
    wr(16'hF008, 8'h00);
    wr(16'hF008, 8'h01);
    if (ofs_on) wr(16'hF00C, 8'h3C);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; line_tick = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(irq_o, 1'b0, "R8 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(irq_o, 1'b0, "R8 after reset");
    // R8: enable cleared, so ticks do nothing
    ticks(300);
    check(irq_o, 1'b0, "R8 enable cleared");
    // R8: counter and offset cleared -> 238 ticks from zero
    wr(16'hF008, 8'h80);
    ticks(237);
    check(irq_o, 1'b0, "R8 counter zero, tick 237");
    ticks(1);
    check(irq_o, 1'b1, "R8 counter zero, tick 238");
    // R7 sticky
    ticks(20);
    check(irq_o, 1'b1, "R7 stays high");
    // R4 ack
    wr(16'hF008, 8'h01);
    check(irq_o, 1'b0, "R4 ack");
    // Sweep: R1 R2 R5 R6 R7 over every start value, both offsets
    for (int o = 0; o < 2; o++) begin
      for (int v = 0; v < 256; v++) begin
        int k;
        setup(o[0]);
        load(v[7:0]);
        k = ((238 + 16 * o - v - 1 + 512) % 256) + 1;
        ticks(k - 1);
        check(irq_o, 1'b0, $sformatf("R1 R2 R6 R7 v=%0d ofs=%0d before", v, 16 * o));
        ticks(1);
        check(irq_o, 1'b1, $sformatf("R5 R7 v=%0d ofs=%0d fire", v, 16 * o));
      end
    end
    // R3: zero enable freezes counting and clears the offset
    setup(1'b1);
    load(8'd237);
    wr(16'hF008, 8'h00);
    ticks(5);
    check(irq_o, 1'b0, "R3 enable zero no count");
    wr(16'hF008, 8'h02);
    ticks(1);
    check(irq_o, 1'b1, "R3 offset cleared by zero enable");
    // R9: unmapped writes have no effect
    setup(1'b0);
    load(8'd236);
    wr(16'hF800, 8'h00);
    wr(16'h7008, 8'h00);
    wr(16'hF80C, 8'hFF);
    wr(16'hF010 | 16'h0800, 8'h0F);
    ticks(1);
    check(irq_o, 1'b0, "R9 unmapped, first tick");
    ticks(1);
    check(irq_o, 1'b1, "R9 unmapped, second tick");
    // R1 aliasing under the mask: 0xF7F3 decodes as low nibble
    setup(1'b0);
    load(8'd0);
    wr(16'hF7F3, 8'hFD);
    wr(16'hF004, 8'h0E);
    ticks(1);
    check(irq_o, 1'b1, "R1 R2 alias load 237");
    // R10: nibble write with simultaneous tick drops the tick
    setup(1'b0);
    load(8'd0);
    wr(16'hF004, 8'h0E);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'hF000; wr_data = 8'h0D; line_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; line_tick = 1'b0;
    check(irq_o, 1'b0, "R10 write beats tick");
    ticks(1);
    check(irq_o, 1'b1, "R10 next tick fires");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule